// File: doc/BRIEF.md
# Cache Way-Activation Resize Controller

This block decides how many ways of a set-associative cache are switched on. Every cache access is presented as one event on a valid/ready stream. A hit event carries the recency rank of the line that was hit, where rank 0 is the most recently used line. A miss event carries no rank. The block collects a histogram of hit ranks over a fixed window of accepted accesses. At the end of each window it judges how tightly the hits cluster near the most-recent end of the recency stack, and it raises a raw request to add a way, to remove a way, or to do nothing.

Raw requests do not switch ways directly. They first pass through a small saturating counter with hysteresis. That counter is asymmetric: giving up a way takes more agreeing windows than gaining one. When the requests flip back and forth, the counter returns to its midpoint, so no way is switched.

Adding a way takes effect at once on the enable mask. Removing a way first asks the surrounding cache to flush that way through a request/acknowledge pair. The mask bit is cleared only once that flush is acknowledged.

Top module: `way_resize_ctrl`

## Requirements
- R1: After reset every way is enabled (`way_mask` all ones, `active_ways` = NUM_WAYS), `flush_req` is 0 and `acc_ready` is 1.
- R2: A window is exactly INTERVAL accepted access events, whether they are hits or misses. Misses count toward the window but add nothing to the histogram, and the histogram is cleared for each new window.
- R3: At the end of a window, if hits at ranks below TOPK, multiplied by 16, exceed SHRINK_FRAC times the total number of hits, the raw request is shrink.
- R4: At the end of a window, a window with zero hits gives a grow request. Otherwise, if the top-rank hits multiplied by 16 fall below GROW_FRAC times the total hits, the request is grow. Any result between the two thresholds gives no request.
- R5: A grow request is dropped when all ways are already enabled. A shrink request is dropped when only one way is enabled. A dropped request leaves the filter counter unchanged.
- R6: The 3-bit filter counter starts at 4. A shrink request steps it down by 1 and commits a shrink when it reaches 0. A grow request steps it up by 2, saturating at 7, and commits a grow at 7. After any commit the counter returns to 4. As a result, 4 consecutive shrink windows or 2 consecutive grow windows cause an action.
- R7: A grow request while the counter is below 4, or a shrink request while it is above 4, returns the counter to 4. Strictly alternating requests therefore never change the mask.
- R8: A committed grow sets bit `active_ways` of `way_mask`, so the enabled ways are always bits 0 to `active_ways`-1. This change is visible three clock edges after the edge that accepts the window's last access.
- R9: A committed shrink raises `flush_req` with `flush_way` equal to the highest enabled index, on the same edge a grow would take effect. `flush_req`, `flush_way` and `way_mask` then hold until an edge samples `flush_ack` high. That edge clears the mask bit, decrements `active_ways` and drops `flush_req`.
- R10: While `flush_req` is high, `acc_ready` is 0 and no access event is accepted. An access is taken only on an edge where `acc_valid` and `acc_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event present |
| acc_ready | output | 1 | Controller accepts an access event this cycle |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| acc_rank | input | $clog2(NUM_WAYS) | Recency rank of the hit line, 0 = most recent |
| flush_req | output | 1 | Request to flush the way being disabled |
| flush_way | output | $clog2(NUM_WAYS) | Index of the way to flush |
| flush_ack | input | 1 | Flush of `flush_way` has completed |
| way_mask | output | NUM_WAYS | Per-way enable, bit i enables way i |
| active_ways | output | $clog2(NUM_WAYS+1) | Number of enabled ways |

## Verification
The hardest state to reach from the ports is a committed action. It depends on a run of agreeing windows, each made of many accesses, together with the hidden counter state left by earlier windows and the dropped requests at the associativity limits. The bench therefore runs a small configuration (4 ways, 16-access windows) and sweeps the split of each window between rank-0 hits, deep-rank hits and misses over every value. A second arithmetic model of the classifier and hysteresis counter predicts, window by window, when a grow or a flush must appear. Dedicated runs drive the count down to one way and up to all ways, and alternate opposite requests, to reach the saturation and snap-back corners.

// File: rtl/way_resize_pkg.sv
package way_resize_pkg;
  // fractions are expressed in sixteenths
  localparam int FRAC_SHIFT = 4;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_SHRINK = 2'd1,
    REQ_GROW   = 2'd2
  } resize_req_e;
endpackage

// File: rtl/rank_histogram.sv
module rank_histogram #(
  parameter int NUM_WAYS = 8,
  parameter int INTERVAL = 1024,
  parameter int TOPK     = 2,
  localparam int RW  = $clog2(NUM_WAYS),
  localparam int CW  = $clog2(INTERVAL + 1),
  localparam int ICW = $clog2(INTERVAL),
  localparam int SW  = CW + RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_take,
  input  logic          acc_hit,
  input  logic [RW-1:0] acc_rank,
  output logic          iv_done,
  output logic [SW-1:0] top_sum,
  output logic [SW-1:0] hit_sum
);
  localparam logic [CW-1:0]  BIN_MAX = {CW{1'b1}};
  localparam logic [ICW-1:0] IV_LAST = ICW'(INTERVAL - 1);

  logic [CW-1:0]  bins_q [NUM_WAYS];
  logic [CW-1:0]  bins_d [NUM_WAYS];
  logic [ICW-1:0] iv_q;
  logic           last_take;
  logic [SW-1:0]  top_d, hit_d;

  assign last_take = acc_take && (iv_q == IV_LAST);

  // one saturating bin per recency rank
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_bin
    always_comb begin
      bins_d[g] = bins_q[g];
      if (acc_take && acc_hit && (acc_rank == RW'(g)) && (bins_q[g] != BIN_MAX))
        bins_d[g] = bins_q[g] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || last_take) bins_q[g] <= '0;
      else                     bins_q[g] <= bins_d[g];
    end
  end

  always_comb begin
    top_d = '0;
    hit_d = '0;
    for (int r = 0; r < NUM_WAYS; r++) begin
      hit_d = hit_d + SW'(bins_d[r]);
      if (r < TOPK) top_d = top_d + SW'(bins_d[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iv_q    <= '0;
      iv_done <= 1'b0;
      top_sum <= '0;
      hit_sum <= '0;
    end else begin
      iv_done <= last_take;
      if (acc_take) iv_q <= last_take ? '0 : iv_q + 1'b1;
      if (last_take) begin
        top_sum <= top_d;
        hit_sum <= hit_d;
      end
    end
  end
endmodule

// File: rtl/locality_classifier.sv
module locality_classifier
  import way_resize_pkg::*;
#(
  parameter int NUM_WAYS    = 8,
  parameter int SW          = 14,
  parameter int SHRINK_FRAC = 12,
  parameter int GROW_FRAC   = 6,
  localparam int AW = $clog2(NUM_WAYS + 1),
  localparam int PW = SW + FRAC_SHIFT + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iv_done,
  input  logic [SW-1:0] top_sum,
  input  logic [SW-1:0] hit_sum,
  input  logic [AW-1:0] active_ways,
  output resize_req_e   raw_req
);
  logic [PW-1:0] top_scaled, shrink_lim, grow_lim;
  logic          want_shrink, want_grow, can_shrink, can_grow;

  always_comb begin
    top_scaled  = PW'(top_sum) << FRAC_SHIFT;
    shrink_lim  = PW'(hit_sum) * PW'(SHRINK_FRAC);
    grow_lim    = PW'(hit_sum) * PW'(GROW_FRAC);
    want_shrink = (hit_sum != '0) && (top_scaled > shrink_lim);
    want_grow   = (hit_sum == '0) || (top_scaled < grow_lim);
    can_shrink  = active_ways > AW'(1);
    can_grow    = active_ways < AW'(NUM_WAYS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_req <= REQ_NONE;
    else if (iv_done && want_shrink && can_shrink) raw_req <= REQ_SHRINK;
    else if (iv_done && want_grow && can_grow)     raw_req <= REQ_GROW;
    else                                           raw_req <= REQ_NONE;
  end
endmodule

// File: rtl/hysteresis_filter.sv
module hysteresis_filter
  import way_resize_pkg::*;
#(
  parameter int FW          = 3,
  parameter int SHRINK_STEP = 1,
  parameter int GROW_STEP   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  resize_req_e raw_req,
  output logic        cmd_shrink,
  output logic        cmd_grow
);
  localparam logic [FW-1:0] CNT_MAX = {FW{1'b1}};
  localparam logic [FW-1:0] CNT_MID = FW'(1 << (FW - 1));
  localparam logic [FW-1:0] S_STEP  = FW'(SHRINK_STEP);
  localparam logic [FW-1:0] G_STEP  = FW'(GROW_STEP);

  logic [FW-1:0] cnt_q, cnt_step;

  always_comb begin
    cnt_step = cnt_q;
    if (raw_req == REQ_SHRINK) begin
      if (cnt_q > CNT_MID)       cnt_step = CNT_MID;
      else if (cnt_q <= S_STEP)  cnt_step = '0;
      else                       cnt_step = cnt_q - S_STEP;
    end else if (raw_req == REQ_GROW) begin
      if (cnt_q < CNT_MID)                  cnt_step = CNT_MID;
      else if (cnt_q >= CNT_MAX - G_STEP)   cnt_step = CNT_MAX;
      else                                  cnt_step = cnt_q + G_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= CNT_MID;
      cmd_shrink <= 1'b0;
      cmd_grow   <= 1'b0;
    end else begin
      cmd_shrink <= 1'b0;
      cmd_grow   <= 1'b0;
      if (raw_req == REQ_SHRINK && cnt_step == '0) begin
        cmd_shrink <= 1'b1;
        cnt_q      <= CNT_MID;
      end else if (raw_req == REQ_GROW && cnt_step == CNT_MAX) begin
        cmd_grow <= 1'b1;
        cnt_q    <= CNT_MID;
      end else begin
        cnt_q <= cnt_step;
      end
    end
  end
endmodule

// File: rtl/way_mask_ctrl.sv
module way_mask_ctrl #(
  parameter int NUM_WAYS = 8,
  localparam int RW = $clog2(NUM_WAYS),
  localparam int AW = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_shrink,
  input  logic                cmd_grow,
  input  logic                flush_ack,
  output logic                flush_req,
  output logic [RW-1:0]       flush_way,
  output logic [NUM_WAYS-1:0] way_mask,
  output logic [AW-1:0]       active_ways
);
  logic [NUM_WAYS-1:0] grow_bit, drop_bit;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_sel
    assign grow_bit[g] = (active_ways == AW'(g));
    assign drop_bit[g] = (flush_way == RW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      way_mask    <= '1;
      active_ways <= AW'(NUM_WAYS);
      flush_req   <= 1'b0;
      flush_way   <= '0;
    end else if (flush_req) begin
      if (flush_ack) begin
        way_mask    <= way_mask & ~drop_bit;
        active_ways <= active_ways - 1'b1;
        flush_req   <= 1'b0;
      end
    end else if (cmd_shrink) begin
      flush_req <= 1'b1;
      flush_way <= RW'(active_ways - 1'b1);
    end else if (cmd_grow) begin
      way_mask    <= way_mask | grow_bit;
      active_ways <= active_ways + 1'b1;
    end
  end
endmodule

// File: rtl/way_resize_ctrl.sv
module way_resize_ctrl
  import way_resize_pkg::*;
#(
  parameter int NUM_WAYS    = 8,
  parameter int INTERVAL    = 1024,
  parameter int TOPK        = 2,
  parameter int SHRINK_FRAC = 12,
  parameter int GROW_FRAC   = 6,
  localparam int RW = $clog2(NUM_WAYS),
  localparam int AW = $clog2(NUM_WAYS + 1),
  localparam int SW = $clog2(INTERVAL + 1) + RW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic                acc_hit,
  input  logic [RW-1:0]       acc_rank,
  output logic                flush_req,
  output logic [RW-1:0]       flush_way,
  input  logic                flush_ack,
  output logic [NUM_WAYS-1:0] way_mask,
  output logic [AW-1:0]       active_ways
);
  logic          acc_take, iv_done, cmd_shrink, cmd_grow;
  logic [SW-1:0] top_sum, hit_sum;
  resize_req_e   raw_req;

  assign acc_ready = !flush_req;
  assign acc_take  = acc_valid && acc_ready;

  rank_histogram #(.NUM_WAYS(NUM_WAYS), .INTERVAL(INTERVAL), .TOPK(TOPK)) hist_i (
    .clk(clk), .rst_n(rst_n), .acc_take(acc_take), .acc_hit(acc_hit),
    .acc_rank(acc_rank), .iv_done(iv_done), .top_sum(top_sum), .hit_sum(hit_sum)
  );

  locality_classifier #(
    .NUM_WAYS(NUM_WAYS), .SW(SW), .SHRINK_FRAC(SHRINK_FRAC), .GROW_FRAC(GROW_FRAC)
  ) class_i (
    .clk(clk), .rst_n(rst_n), .iv_done(iv_done), .top_sum(top_sum),
    .hit_sum(hit_sum), .active_ways(active_ways), .raw_req(raw_req)
  );

  hysteresis_filter #(.FW(3), .SHRINK_STEP(1), .GROW_STEP(2)) filt_i (
    .clk(clk), .rst_n(rst_n), .raw_req(raw_req),
    .cmd_shrink(cmd_shrink), .cmd_grow(cmd_grow)
  );

  way_mask_ctrl #(.NUM_WAYS(NUM_WAYS)) mask_i (
    .clk(clk), .rst_n(rst_n), .cmd_shrink(cmd_shrink), .cmd_grow(cmd_grow),
    .flush_ack(flush_ack), .flush_req(flush_req), .flush_way(flush_way),
    .way_mask(way_mask), .active_ways(active_ways)
  );
endmodule

// File: rtl/way_resize_ctrl_chk.sv
module way_resize_ctrl_chk #(
  parameter int NUM_WAYS = 8,
  localparam int RW = $clog2(NUM_WAYS),
  localparam int AW = $clog2(NUM_WAYS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_valid,
  input logic                acc_ready,
  input logic                flush_req,
  input logic [RW-1:0]       flush_way,
  input logic                flush_ack,
  input logic [NUM_WAYS-1:0] way_mask,
  input logic [AW-1:0]       active_ways
);
  // R5
  min_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_mask) >= 1);

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_mask ^ $past(way_mask)) <= 1);

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_mask) == int'(active_ways));

  // R9
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> (flush_req && $stable(flush_way) && $stable(way_mask)));

  // R9
  drop_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(way_mask) < $countones($past(way_mask))) |-> $past(flush_req && flush_ack));

  // R10
  stall_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && acc_valid) |-> !acc_ready);
endmodule

bind way_resize_ctrl way_resize_ctrl_chk #(.NUM_WAYS(NUM_WAYS)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .flush_req(flush_req), .flush_way(flush_way), .flush_ack(flush_ack),
  .way_mask(way_mask), .active_ways(active_ways)
);

// File: tb/way_resize_ctrl_tb_top.sv
module way_resize_ctrl_tb_top;
  localparam int NW = 4;
  localparam int IV = 16;
  localparam int SF = 12;
  localparam int GF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_hit = 1'b0, flush_ack = 1'b0;
  logic [1:0] acc_rank = '0;
  logic       acc_ready, flush_req;
  logic [1:0] flush_way;
  logic [3:0] way_mask;
  logic [2:0] active_ways;

  int checks = 0, fails = 0;
  int m_cnt = 4, m_act = NW;
  bit done = 0;

  always #4 clk = ~clk;

  way_resize_ctrl #(.NUM_WAYS(NW), .INTERVAL(IV), .TOPK(1),
                    .SHRINK_FRAC(SF), .GROW_FRAC(GF)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_hit(acc_hit), .acc_rank(acc_rank), .flush_req(flush_req),
    .flush_way(flush_way), .flush_ack(flush_ack), .way_mask(way_mask),
    .active_ways(active_ways)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mask_of(input int n);
    return (1 << n) - 1;
  endfunction

  // one window: t rank-0 hits, o rank-3 hits, m misses (t+o+m = IV)
  task automatic run_iv(input int t, input int o, input int m, input string grp);
    int req;     // 0 none, 1 shrink, 2 grow
    int act;     // 0 none, 1 shrink, 2 grow
    string tag;
    for (int k = 0; k < t + o + m; k++) begin
      @(negedge clk);
      acc_valid = 1'b1;
      acc_hit   = (k < t + o);
      acc_rank  = (k < t) ? 2'd0 : 2'd3;
    end
    @(negedge clk);
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    // reference model
    req = 0;
    if ((t + o) > 0 && t * 16 > SF * (t + o)) req = 1;
    else if ((t + o) == 0 || t * 16 < GF * (t + o)) req = 2;
    tag = (req == 1) ? "R3" : (req == 2) ? "R4" : "R6";
    if (req == 1 && m_act == 1) begin req = 0; tag = "R5"; end
    if (req == 2 && m_act == NW) begin req = 0; tag = "R5"; end
    act = 0;
    if (req == 1) begin
      if (m_cnt > 4) m_cnt = 4;
      else if (m_cnt <= 1) begin act = 1; m_cnt = 4; end
      else m_cnt = m_cnt - 1;
    end else if (req == 2) begin
      if (m_cnt < 4) m_cnt = 4;
      else if (m_cnt >= 5) begin act = 2; m_cnt = 4; end
      else m_cnt = m_cnt + 2;
    end
    if (grp.len() > 0) tag = grp;
    if (act == 1) begin
      check("R9 flush_req raised", int'(flush_req), 1);
      check("R9 flush_way", int'(flush_way), m_act - 1);
      check("R9 mask held", int'(way_mask), mask_of(m_act));
      acc_valid = 1'b1; acc_hit = 1'b1; acc_rank = 2'd0;
      repeat (3) @(negedge clk);
      check("R10 ready low in flush", int'(acc_ready), 0);
      acc_valid = 1'b0;
      check("R9 still waiting", int'(flush_req), 1);
      flush_ack = 1'b1;
      @(negedge clk);
      flush_ack = 1'b0;
      m_act = m_act - 1;
      check("R9 flush_req dropped", int'(flush_req), 0);
      check("R10 ready back", int'(acc_ready), 1);
    end else begin
      check({tag, " no flush"}, int'(flush_req), 0);
      if (act == 2) begin
        m_act = m_act + 1;
        tag = "R8";
      end
    end
    check({tag, " mask"}, int'(way_mask), mask_of(m_act));
    check({tag, " active"}, int'(active_ways), m_act);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mask", int'(way_mask), 15);
    check("R1 active", int'(active_ways), NW);
    check("R1 flush_req", int'(flush_req), 0);
    check("R1 ready", int'(acc_ready), 1);

    // R3/R4/R6: sweep top-rank share over every value, two passes
    for (int p = 0; p < 2; p++)
      for (int t = 0; t <= IV; t++) run_iv(t, IV - t, 0, "");

    // R5: push down to a single way and beyond
    for (int k = 0; k < 20; k++) run_iv(IV, 0, 0, "");
    check("R5 floor active", int'(active_ways), 1);

    // R2: all-miss windows grow; misses add no hits
    for (int k = 0; k < 10; k++) run_iv(0, 0, IV, "R2");
    check("R5 ceiling active", int'(active_ways), NW);

    // R7: alternating shrink / grow requests change nothing
    for (int k = 0; k < 4; k++) run_iv(IV, 0, 0, "");
    for (int k = 0; k < 12; k++) begin
      if (k % 2 == 0) run_iv(0, IV, 0, "R7");
      else            run_iv(IV, 0, 0, "R7");
    end

    // R2: misses dilute nothing; sweep miss count with fixed hit split
    for (int m = 0; m <= 14; m++) run_iv(2, IV - 2 - m, m, "R2");
    for (int m = 0; m <= 15; m++) run_iv(IV - m, 0, m, "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule